// File: doc/BRIEF.md
# PHY Management Register Bank

This block holds the thirty-two 16-bit management registers of a gigabit PHY. A host reaches them over a two-wire serial bus. The block is a slave on that bus and answers only at its own fixed 7-bit device address. Every access moves one whole 16-bit word. A write sends a register-select byte and then two data bytes. A read sends the register-select byte, then a repeated start, and then clocks out two data bytes.

Each bit of a register follows its own access rule:
- some bits are fixed,
- some are plain read/write,
- some clear themselves one cycle after they are written,
- some latch a link event until the host reads them,
- some are counters that stop at all ones and empty when they are read.

The link logic drives the status and counter inputs as levels or one-cycle strobes. The reset, auto-negotiation enable and restart bits are driven out to the rest of the PHY.

Top module: `phy_mgmt_regs`

## Requirements
- R1: The slave answers only the 7-bit device address 1010110 (the eighth bit is read=1/write=0). Any other address is not acknowledged, and the rest of that transaction changes no register.
- R2: The register-select byte must have the form 000yyyyy, where yyyyy picks register 0 to 31. A select byte with any of its upper three bits set is not acknowledged and leaves every register unchanged.
- R3: A word is moved as two bytes, high byte first. A write takes effect only after the low byte has been acknowledged.
- R4: After hardware reset the registers read as follows: control (0) = 0x1140, status (1) = 0x0149, advertisement (4) = 0x8001, master/slave control (9) = 0x0E00, and every other register = 0x0000.
- R5: Some bits cannot be written. In register 4, bits 4:0 always read 00001. In register 0, bits 5:0 read 0. In register 9, bits 7:0 read 0. Register 1 and all unimplemented registers ignore writes, and the unimplemented registers read 0x0000.
- R6: Bit 0.15 (PHY reset) and bit 0.9 (restart auto-negotiation) clear themselves. Writing a 1 to either bit produces exactly one single-cycle pulse on its output, and the bit then reads back as 0.
- R7: The auto-negotiation enable output always equals bit 0.12.
- R8: Link status (bit 1.2) latches low. Any cycle with the link down clears it. Once a read of register 1 completes, the bit reloads from the current link level.
- R9: Remote fault (bit 1.4) latches high. A one-cycle fault strobe sets it, and it stays set until a read of register 1 completes.
- R10: Register 10, bits 7:0 count idle-error strobes. The count stops at 0xFF and does not wrap. It clears when a read of register 10 completes.
- R11: Register 21 counts receive-error strobes. The count stops at 0xFFFF and does not wrap. It clears when a read of register 21 completes.
- R12: Bit 10.15 (master/slave fault) sets when the count of failed-resolution strobes reaches 7. A completed read of register 10 clears both the bit and that count.
- R13: The clear-on-read and reload effects happen only when the low byte of a read has been clocked out and its acknowledge bit has been clocked. A read the host abandons with a not-acknowledge after the high byte clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| scl_i | input | 1 | Serial bus clock, sampled through a synchronizer |
| sda_i | input | 1 | Serial bus data as seen on the wire |
| sda_oe_o | output | 1 | High pulls the data wire low (open-drain drive) |
| link_up_i | input | 1 | Current link level from the link logic |
| remote_fault_i | input | 1 | Strobe for a remote fault event |
| idle_err_i | input | 1 | Strobe for one idle error |
| rx_err_i | input | 1 | Strobe for one receive error |
| ms_fail_i | input | 1 | Strobe for one failed master/slave resolution |
| sw_reset_o | output | 1 | Single-cycle PHY reset request (bit 0.15) |
| an_enable_o | output | 1 | Auto-negotiation enable (bit 0.12) |
| an_restart_o | output | 1 | Single-cycle auto-negotiation restart (bit 0.9) |

## Verification
The serial clock goes through a synchronizer of SYNC_STAGES flops and one edge flop. Every bus decision therefore lands three cycles after the wire edge:
- the write strobe follows the falling clock that ends the low data byte;
- the register update and any self-clearing pulse come one cycle after that strobe;
- the clear-on-read fires on the rising clock of the low byte's acknowledge bit.

The bench moves the bus only on negative clock edges, and each bus quarter-period is eight system cycles. It samples read data in the middle of the high phase of the serial clock, and reads registers or outputs only after a whole transaction and its stop have finished. Each result is then settled by many cycles when it is checked. Single-cycle pulses are counted on every negative edge over the whole window of a write.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 5;
  localparam int IDLE_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL   = 5'd0;
  localparam logic [ADDR_W-1:0] A_STAT   = 5'd1;
  localparam logic [ADDR_W-1:0] A_ADV    = 5'd4;
  localparam logic [ADDR_W-1:0] A_MSCTL  = 5'd9;
  localparam logic [ADDR_W-1:0] A_MSSTAT = 5'd10;
  localparam logic [ADDR_W-1:0] A_RXERR  = 5'd21;

  localparam logic [REG_W-1:0] CTRL_RST    = 16'h1140;
  localparam logic [REG_W-1:0] CTRL_WMASK  = 16'hFFC0;
  localparam logic [REG_W-1:0] CTRL_SCMASK = 16'h8200;
  localparam logic [REG_W-1:0] STAT_BASE   = 16'h0149;
  localparam logic [REG_W-1:0] ADV_RST     = 16'h8001;
  localparam logic [REG_W-1:0] ADV_WMASK   = 16'hFFE0;
  localparam logic [REG_W-1:0] MSCTL_RST   = 16'h0E00;
  localparam logic [REG_W-1:0] MSCTL_WMASK = 16'hFF00;

  typedef enum logic [3:0] {
    TW_IDLE, TW_DEV, TW_DEV_ACK, TW_ADDR, TW_ADDR_ACK,
    TW_WDATA, TW_WDATA_ACK, TW_RDATA, TW_RACK, TW_RNEXT
  } twi_st_e;

  // writable bits take the new value, fixed bits keep their constant
  function automatic logic [REG_W-1:0] merge_fixed(input logic [REG_W-1:0] wr,
                                                   input logic [REG_W-1:0] mask,
                                                   input logic [REG_W-1:0] fixed);
    return (wr & mask) | (fixed & ~mask);
  endfunction

  function automatic logic [REG_W-1:0] status_word(input logic link, input logic rfault);
    logic [REG_W-1:0] w;
    w = STAT_BASE;
    w[2] = link;
    w[4] = rfault;
    return w;
  endfunction
endpackage

// File: rtl/phy_mgmt_satcnt.sv
module phy_mgmt_satcnt #(
  parameter int W     = 8,
  parameter int LIMIT = 255
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] TOP = W'(LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                q <= '0;
    else if (clr)              q <= '0;
    else if (inc && q != TOP)  q <= q + 1'b1;
  end
endmodule

// File: rtl/phy_mgmt_twi_slave.sv
module phy_mgmt_twi_slave
  import phy_mgmt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1010110,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [REG_W-1:0]  rd_word_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [REG_W-1:0]  wdata_o,
  output logic              wr_o,
  output logic              rd_done_o
);
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_p, sda_p, scl_h, sda_h;
  logic start_ev, stop_ev, rise_ev, fall_ev;
  twi_st_e st;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txsh, snap_lo, wbuf;
  logic rnw, hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1; sda_sync <= '1; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_p    <= scl_sync[SYNC_STAGES-1];
      sda_p    <= sda_sync[SYNC_STAGES-1];
    end
  end

  assign scl_h    = scl_sync[SYNC_STAGES-1];
  assign sda_h    = sda_sync[SYNC_STAGES-1];
  assign start_ev = scl_h && scl_p && sda_p && !sda_h;
  assign stop_ev  = scl_h && scl_p && !sda_p && sda_h;
  assign rise_ev  = scl_h && !scl_p;
  assign fall_ev  = !scl_h && scl_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= TW_IDLE; bitcnt <= '0; shreg <= '0; txsh <= '0; snap_lo <= '0;
      wbuf <= '0; rnw <= 1'b0; hi <= 1'b1; sda_oe_o <= 1'b0;
      addr_o <= '0; wdata_o <= '0; wr_o <= 1'b0; rd_done_o <= 1'b0;
    end else begin
      wr_o      <= 1'b0;
      rd_done_o <= 1'b0;
      if (start_ev) begin
        st <= TW_DEV; bitcnt <= '0; sda_oe_o <= 1'b0;
      end else if (stop_ev) begin
        st <= TW_IDLE; sda_oe_o <= 1'b0;
      end else if (rise_ev) begin
        case (st)
          TW_DEV, TW_ADDR, TW_WDATA: begin
            shreg  <= {shreg[6:0], sda_h};
            bitcnt <= bitcnt + 4'd1;
          end
          TW_RDATA: bitcnt <= bitcnt + 4'd1;
          TW_RACK: begin
            if (!hi) begin
              rd_done_o <= 1'b1;
              st        <= TW_IDLE;
            end else if (!sda_h) st <= TW_RNEXT;
            else                 st <= TW_IDLE;
          end
          default: ;
        endcase
      end else if (fall_ev) begin
        case (st)
          TW_DEV: if (bitcnt == 4'd8) begin
            if (shreg[7:1] == DEV_ADDR) begin
              sda_oe_o <= 1'b1; rnw <= shreg[0]; st <= TW_DEV_ACK;
            end else st <= TW_IDLE;
          end
          TW_DEV_ACK: begin
            bitcnt <= '0; hi <= 1'b1;
            if (rnw) begin
              snap_lo  <= rd_word_i[7:0];
              txsh     <= {rd_word_i[14:8], 1'b0};
              sda_oe_o <= ~rd_word_i[15];
              st       <= TW_RDATA;
            end else begin
              sda_oe_o <= 1'b0; st <= TW_ADDR;
            end
          end
          TW_ADDR: if (bitcnt == 4'd8) begin
            if (shreg[7:5] == 3'b000) begin
              sda_oe_o <= 1'b1; addr_o <= shreg[4:0]; st <= TW_ADDR_ACK;
            end else st <= TW_IDLE;
          end
          TW_ADDR_ACK: begin
            sda_oe_o <= 1'b0; bitcnt <= '0; hi <= 1'b1; st <= TW_WDATA;
          end
          TW_WDATA: if (bitcnt == 4'd8) begin
            sda_oe_o <= 1'b1; st <= TW_WDATA_ACK;
            if (hi) wbuf <= shreg;
            else begin
              wdata_o <= {wbuf, shreg}; wr_o <= 1'b1;
            end
          end
          TW_WDATA_ACK: begin
            sda_oe_o <= 1'b0; bitcnt <= '0; hi <= ~hi; st <= TW_WDATA;
          end
          TW_RDATA: begin
            if (bitcnt == 4'd8) begin
              sda_oe_o <= 1'b0; st <= TW_RACK;
            end else begin
              sda_oe_o <= ~txsh[7]; txsh <= {txsh[6:0], 1'b0};
            end
          end
          TW_RNEXT: begin
            bitcnt <= '0; hi <= 1'b0; sda_oe_o <= ~snap_lo[7];
            txsh <= {snap_lo[6:0], 1'b0}; st <= TW_RDATA;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/phy_mgmt_bank.sv
module phy_mgmt_bank
  import phy_mgmt_pkg::*;
#(
  parameter int RX_CNT_W      = 16,
  parameter int MS_FAIL_LIMIT = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_i,
  input  logic                rd_done_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  input  logic                link_up_i,
  input  logic                remote_fault_i,
  input  logic                idle_err_i,
  input  logic                rx_err_i,
  input  logic                ms_fail_i,
  output logic                sw_reset_o,
  output logic                an_enable_o,
  output logic                an_restart_o,
  output logic                link_lat_o,
  output logic                rf_lat_o,
  output logic [IDLE_W-1:0]   idle_cnt_o,
  output logic [RX_CNT_W-1:0] rx_cnt_o,
  output logic                ms_fault_o
);
  localparam int FAIL_W = $clog2(MS_FAIL_LIMIT + 1);

  logic [REG_W-1:0] r_ctrl, r_adv, r_msctl;
  logic [FAIL_W-1:0] fail_cnt;
  logic rd_stat, rd_msstat, rd_rxerr;

  assign rd_stat   = rd_done_i && addr_i == A_STAT;
  assign rd_msstat = rd_done_i && addr_i == A_MSSTAT;
  assign rd_rxerr  = rd_done_i && addr_i == A_RXERR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_ctrl <= CTRL_RST; r_adv <= ADV_RST; r_msctl <= MSCTL_RST;
      link_lat_o <= 1'b0; rf_lat_o <= 1'b0;
    end else begin
      if (wr_i && addr_i == A_CTRL) r_ctrl <= merge_fixed(wdata_i, CTRL_WMASK, '0);
      else                          r_ctrl <= r_ctrl & ~CTRL_SCMASK;
      if (wr_i && addr_i == A_ADV)   r_adv   <= merge_fixed(wdata_i, ADV_WMASK, ADV_RST);
      if (wr_i && addr_i == A_MSCTL) r_msctl <= merge_fixed(wdata_i, MSCTL_WMASK, '0);
      link_lat_o <= rd_stat ? link_up_i      : (link_lat_o & link_up_i);
      rf_lat_o   <= rd_stat ? remote_fault_i : (rf_lat_o | remote_fault_i);
    end
  end

  phy_mgmt_satcnt #(.W(IDLE_W), .LIMIT((1 << IDLE_W) - 1)) u_idle_cnt (
    .clk(clk), .rst_n(rst_n), .clr(rd_msstat), .inc(idle_err_i), .q(idle_cnt_o));
  phy_mgmt_satcnt #(.W(RX_CNT_W), .LIMIT((1 << RX_CNT_W) - 1)) u_rx_cnt (
    .clk(clk), .rst_n(rst_n), .clr(rd_rxerr), .inc(rx_err_i), .q(rx_cnt_o));
  phy_mgmt_satcnt #(.W(FAIL_W), .LIMIT(MS_FAIL_LIMIT)) u_fail_cnt (
    .clk(clk), .rst_n(rst_n), .clr(rd_msstat), .inc(ms_fail_i), .q(fail_cnt));

  assign ms_fault_o   = fail_cnt == FAIL_W'(MS_FAIL_LIMIT);
  assign sw_reset_o   = r_ctrl[15];
  assign an_restart_o = r_ctrl[9];
  assign an_enable_o  = r_ctrl[12];

  always_comb begin
    case (addr_i)
      A_CTRL:   rdata_o = r_ctrl;
      A_STAT:   rdata_o = status_word(link_lat_o, rf_lat_o);
      A_ADV:    rdata_o = r_adv;
      A_MSCTL:  rdata_o = r_msctl;
      A_MSSTAT: rdata_o = {ms_fault_o, {(REG_W-IDLE_W-1){1'b0}}, idle_cnt_o};
      A_RXERR:  rdata_o = REG_W'(rx_cnt_o);
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR      = 7'b1010110,
  parameter int         SYNC_STAGES   = 2,
  parameter int         RX_CNT_W      = 16,
  parameter int         MS_FAIL_LIMIT = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  input  logic link_up_i,
  input  logic remote_fault_i,
  input  logic idle_err_i,
  input  logic rx_err_i,
  input  logic ms_fail_i,
  output logic sw_reset_o,
  output logic an_enable_o,
  output logic an_restart_o
);
  logic [ADDR_W-1:0]   acc_addr;
  logic [REG_W-1:0]    wr_data, rd_word;
  logic                wr_pulse, rd_done;
  logic                link_lat, rf_lat, ms_fault;
  logic [IDLE_W-1:0]   idle_cnt;
  logic [RX_CNT_W-1:0] rx_cnt;

  phy_mgmt_twi_slave #(.DEV_ADDR(DEV_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_twi (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe_o(sda_oe_o),
    .rd_word_i(rd_word), .addr_o(acc_addr), .wdata_o(wr_data),
    .wr_o(wr_pulse), .rd_done_o(rd_done));

  phy_mgmt_bank #(.RX_CNT_W(RX_CNT_W), .MS_FAIL_LIMIT(MS_FAIL_LIMIT)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_pulse), .rd_done_i(rd_done),
    .addr_i(acc_addr), .wdata_i(wr_data), .rdata_o(rd_word),
    .link_up_i(link_up_i), .remote_fault_i(remote_fault_i),
    .idle_err_i(idle_err_i), .rx_err_i(rx_err_i), .ms_fail_i(ms_fail_i),
    .sw_reset_o(sw_reset_o), .an_enable_o(an_enable_o), .an_restart_o(an_restart_o),
    .link_lat_o(link_lat), .rf_lat_o(rf_lat), .idle_cnt_o(idle_cnt),
    .rx_cnt_o(rx_cnt), .ms_fault_o(ms_fault));
endmodule

// File: rtl/phy_mgmt_regs_chk.sv
module phy_mgmt_regs_chk #(
  parameter int RX_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sw_reset_o,
  input logic            an_restart_o,
  input logic            link_up_i,
  input logic            remote_fault_i,
  input logic            link_lat,
  input logic            rf_lat,
  input logic [7:0]      idle_cnt,
  input logic [RX_W-1:0] rx_cnt,
  input logic            ms_fault,
  input logic            rd_done,
  input logic [4:0]      acc_addr
);
  logic rd10, rd21;
  assign rd10 = rd_done && acc_addr == 5'd10;
  assign rd21 = rd_done && acc_addr == 5'd21;

  p_reset_selfclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset_o |=> !sw_reset_o);
  p_restart_selfclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    an_restart_o |=> !an_restart_o);
  p_link_latch_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up_i |=> !link_lat);
  p_rf_latch_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    remote_fault_i |=> rf_lat);
  p_idle_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt == 8'hFF && !rd10) |=> idle_cnt == 8'hFF);
  p_rx_no_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt == '1 && !rd21) |=> rx_cnt == '1);
  p_msfault_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd10 |=> !ms_fault);
  p_rx_held_until_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt != '0 && !rd21) |=> rx_cnt != '0);
endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk #(.RX_W(RX_CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_reset_o(sw_reset_o), .an_restart_o(an_restart_o),
  .link_up_i(link_up_i), .remote_fault_i(remote_fault_i), .link_lat(link_lat),
  .rf_lat(rf_lat), .idle_cnt(idle_cnt), .rx_cnt(rx_cnt), .ms_fault(ms_fault),
  .rd_done(rd_done), .acc_addr(acc_addr));

// File: tb/phy_mgmt_regs_tb.sv
module phy_mgmt_regs_tb;
  localparam int         Q   = 8;
  localparam logic [6:0] DEV = 7'b1010110;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic scl = 1'b1, m_low = 1'b0;
  logic sda_oe;
  logic link_up = 1'b0, rfault = 1'b0, idle_err = 1'b0, rx_err = 1'b0, ms_fail = 1'b0;
  logic sw_reset, an_en, an_restart;
  wire  sda_line = !(m_low || sda_oe);

  int checks = 0, errors = 0, n_swrst = 0, n_restart = 0;
  bit finished = 1'b0;

  phy_mgmt_regs u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .link_up_i(link_up), .remote_fault_i(rfault), .idle_err_i(idle_err),
    .rx_err_i(rx_err), .ms_fail_i(ms_fail), .sw_reset_o(sw_reset),
    .an_enable_o(an_en), .an_restart_o(an_restart));

  always @(negedge clk) begin
    if (sw_reset)   n_swrst++;
    if (an_restart) n_restart++;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic qw(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start;
    m_low = 1'b0; qw(); scl = 1'b1; qw(); m_low = 1'b1; qw(); scl = 1'b0; qw();
  endtask

  task automatic bus_stop;
    m_low = 1'b1; qw(); scl = 1'b1; qw(); m_low = 1'b0; qw();
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = !b[i]; qw(); scl = 1'b1; qw(2); scl = 1'b0; qw();
    end
    m_low = 1'b0; qw(); scl = 1'b1; qw(); ack = !sda_line; qw(); scl = 1'b0; qw();
  endtask

  task automatic rbyte(input bit ack, output logic [7:0] b);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl = 1'b1; qw(); b[i] = sda_line; qw(); scl = 1'b0; qw();
    end
    m_low = ack; qw(); scl = 1'b1; qw(2); scl = 1'b0; qw(); m_low = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [15:0] d, output bit ok);
    bit k1, k2, k3, k4;
    bus_start; wbyte({DEV, 1'b0}, k1); wbyte(a, k2);
    wbyte(d[15:8], k3); wbyte(d[7:0], k4); bus_stop;
    ok = k1 && k2 && k3 && k4;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [15:0] d, output bit ok);
    bit k1, k2, k3;
    bus_start; wbyte({DEV, 1'b0}, k1); wbyte(a, k2);
    bus_start; wbyte({DEV, 1'b1}, k3);
    rbyte(1'b1, d[15:8]); rbyte(1'b0, d[7:0]); bus_stop;
    ok = k1 && k2 && k3;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
    logic [15:0] d; bit ok;
    reg_rd(a, d, ok);
    if (!ok) d = 16'hDEAD;
    chk(req, d, exp);
  endtask

  task automatic wr_do(input logic [7:0] a, input logic [15:0] d);
    bit ok;
    reg_wr(a, d, ok);
  endtask

  task automatic pulse(ref logic sig, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sig = 1'b1;
      @(negedge clk) sig = 1'b0;
    end
  endtask

  task automatic t_reset;
    chk("R4 an_enable", {15'b0, an_en}, 16'd1);
    chk("R4 sw_reset", {15'b0, sw_reset}, 16'd0);
    rd_chk("R4 reg0", 8'd0, 16'h1140);
    rd_chk("R4 reg1", 8'd1, 16'h0149);
    rd_chk("R4 reg4", 8'd4, 16'h8001);
    rd_chk("R4 reg9", 8'd9, 16'h0E00);
    rd_chk("R4 reg10", 8'd10, 16'h0000);
    rd_chk("R4 reg21", 8'd21, 16'h0000);
    rd_chk("R4 reg7", 8'd7, 16'h0000);
  endtask

  task automatic t_dev_addr;
    bit ack, ok;
    bus_start; wbyte({7'b1010101, 1'b0}, ack); bus_stop;
    chk("R1 foreign address nack", {15'b0, ack}, 16'd0);
    bus_start; wbyte({7'b1010111, 1'b0}, ack); wbyte(8'd4, ack);
    wbyte(8'h55, ack); wbyte(8'h55, ack); bus_stop;
    rd_chk("R1 foreign write ignored", 8'd4, 16'h8001);
    reg_wr(8'd4, 16'h8001, ok);
    chk("R1 own address acked", {15'b0, ok}, 16'd1);
  endtask

  task automatic t_reg_addr;
    bit k1, k2;
    bus_start; wbyte({DEV, 1'b0}, k1); wbyte(8'h24, k2);
    wbyte(8'h55, k1); wbyte(8'h55, k1); bus_stop;
    chk("R2 bad select nack", {15'b0, k2}, 16'd0);
    rd_chk("R2 bad select ignored", 8'd4, 16'h8001);
  endtask

  task automatic t_word;
    wr_do(8'd4, 16'h12F0);
    rd_chk("R3 high byte first", 8'd4, 16'h12E1);
    wr_do(8'd4, 16'hABCD);
    rd_chk("R5 reg4 fixed bits", 8'd4, 16'hABC1);
    wr_do(8'd9, 16'h1234);
    rd_chk("R5 reg9 low byte", 8'd9, 16'h1200);
    wr_do(8'd7, 16'hFFFF);
    rd_chk("R5 unimplemented", 8'd7, 16'h0000);
    wr_do(8'd1, 16'hFFFF);
    rd_chk("R5 status ignores write", 8'd1, 16'h0149);
    wr_do(8'd0, 16'h113F);
    rd_chk("R5 reg0 low bits", 8'd0, 16'h1100);
  endtask

  task automatic t_selfclear;
    n_swrst = 0; n_restart = 0;
    wr_do(8'd0, 16'h9340);
    chk("R6 reset pulse count", 16'(n_swrst), 16'd1);
    chk("R6 restart pulse count", 16'(n_restart), 16'd1);
    rd_chk("R6 bits read back 0", 8'd0, 16'h1140);
  endtask

  task automatic t_an_en;
    wr_do(8'd0, 16'h0140);
    chk("R7 an_enable off", {15'b0, an_en}, 16'd0);
    wr_do(8'd0, 16'h1140);
    chk("R7 an_enable on", {15'b0, an_en}, 16'd1);
  endtask

  task automatic t_link;
    link_up = 1'b1; qw();
    rd_chk("R8 latched low since reset", 8'd1, 16'h0149);
    rd_chk("R8 reload after read", 8'd1, 16'h014D);
    @(negedge clk) link_up = 1'b0;
    repeat (3) @(negedge clk);
    link_up = 1'b1; qw();
    rd_chk("R8 short drop held", 8'd1, 16'h0149);
    rd_chk("R8 up again", 8'd1, 16'h014D);
  endtask

  task automatic t_rfault;
    pulse(rfault, 1); qw();
    rd_chk("R9 fault latched", 8'd1, 16'h015D);
    rd_chk("R9 fault cleared by read", 8'd1, 16'h014D);
  endtask

  task automatic t_idle;
    pulse(idle_err, 5);
    rd_chk("R10 count 5", 8'd10, 16'h0005);
    rd_chk("R10 cleared", 8'd10, 16'h0000);
    @(negedge clk) idle_err = 1'b1;
    repeat (300) @(negedge clk);
    idle_err = 1'b0;
    rd_chk("R10 saturate", 8'd10, 16'h00FF);
    rd_chk("R10 cleared after saturate", 8'd10, 16'h0000);
  endtask

  task automatic t_rx;
    pulse(rx_err, 3);
    rd_chk("R11 count 3", 8'd21, 16'h0003);
    rd_chk("R11 cleared", 8'd21, 16'h0000);
    @(negedge clk) rx_err = 1'b1;
    repeat (65540) @(negedge clk);
    rx_err = 1'b0;
    rd_chk("R11 saturate", 8'd21, 16'hFFFF);
    rd_chk("R11 cleared after saturate", 8'd21, 16'h0000);
  endtask

  task automatic t_ms;
    pulse(ms_fail, 6);
    rd_chk("R12 six failures", 8'd10, 16'h0000);
    pulse(ms_fail, 7);
    rd_chk("R12 seven failures", 8'd10, 16'h8000);
    rd_chk("R12 cleared by read", 8'd10, 16'h0000);
  endtask

  task automatic t_partial;
    bit k; logic [7:0] hb;
    pulse(idle_err, 4);
    bus_start; wbyte({DEV, 1'b0}, k); wbyte(8'd10, k);
    bus_start; wbyte({DEV, 1'b1}, k); rbyte(1'b0, hb); bus_stop;
    rd_chk("R13 abandoned read kept count", 8'd10, 16'h0004);
    rd_chk("R13 completed read cleared", 8'd10, 16'h0000);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_dev_addr;
    t_reg_addr;
    t_word;
    t_selfclear;
    t_an_en;
    t_link;
    t_rfault;
    t_idle;
    t_rx;
    t_ms;
    t_partial;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule